// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing-generator panel up from cold and takes it back down. It works through a fixed list of steps: register writes, timed waits of a few milliseconds, and one hand-off in each sequence to an external serial command sender, which sets the panel's common-electrode voltage. The block waits for that sender's completion pulse before it goes on. Each register write leaves through a one-entry address/data port with a valid/ready handshake. The serial link below that port is not part of the block.

Power-on and power-off arrive as one-cycle request pulses. A request that comes in while a sequence is running is held and served once the current sequence has ended. The block keeps a flag that says whether the panel has been initialised. A power-on request while that flag is set does not repeat the supply ramp. It only rewrites the phase and resolution registers, so the display mode can change without a power cycle. The resolution select, the common-voltage trim and the phase trim are each sampled once, in the cycle a sequence starts.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `wr_valid`, `vcom_start` and `panel_on` are all 0.
- R2: A power-on request with `panel_on` at 0 produces these writes, as (address, data) in hex, in this order: (6,1F) (3,03) (4,00) (4,04), then a 3 ms wait, then (3,07) (6,09), then the common-voltage hand-off, then (3,17) (4,06), then a 2 ms wait, then (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00), then a 1 ms wait, then (0,resolution). At the end `panel_on` becomes 1.
- R3: One millisecond equals CLK_HZ/1000 clock cycles. Take the accepted write just before a wait and the accepted write just after it. Their spacing is at least the wait length and at most 20 cycles more than that. For a power-off request, the spacing is counted from the request to the first accepted write.
- R4: The hand-off raises `vcom_start` for exactly one cycle, with `vcom_value` and `vcom_base` valid alongside it. No write is offered from that point until `vcom_done` arrives. On power-up the value is `vcom_trim` when `vcom_trim_vld` is 1 and 125 when it is 0, and the base is 0x04.
- R5: The phase data is 0x13 when `res_qvga` is 1. When `res_qvga` is 0, it is `{3'b000, phase_trim, 1'b1}` if `phase_trim_vld` is 1, and 0x01 otherwise.
- R6: The resolution data is 0x00 when `res_qvga` is 0 (full resolution) and 0x01 when it is 1 (quarter resolution).
- R7: A power-on request with `panel_on` at 1 produces only (1,phase) and then (0,resolution). It has no wait and no hand-off, and `panel_on` stays 1.
- R8: A power-off request, whatever the state of `panel_on`, first waits 34 ms. It then produces (4,06) (6,08) (3,14), then a hand-off with value 0 and base 0x14, then (4,04) (3,04) (6,1E) (3,00) (4,00). At the end `panel_on` becomes 0.
- R9: A request that arrives while a sequence is running is served after that sequence ends. When power-off and power-on are both pending, power-off runs first.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R11: `busy` goes to 1 two clock edges after a request pulse. It stays at 1 until the last write of the sequence has been accepted. While `busy` is 0, no write is offered.
- R12: Changes to `res_qvga`, `vcom_trim`, `vcom_trim_vld`, `phase_trim` and `phase_trim_vld` after a sequence has started have no effect on that sequence's writes or hand-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on_req | input | 1 | Power-on request pulse |
| pwr_off_req | input | 1 | Power-off request pulse |
| res_qvga | input | 1 | 1 selects quarter resolution, 0 selects full resolution |
| vcom_trim | input | 8 | Common-voltage trim code |
| vcom_trim_vld | input | 1 | `vcom_trim` is valid |
| phase_trim | input | 4 | Phase trim for full resolution |
| phase_trim_vld | input | 1 | `phase_trim` is valid |
| wr_valid | output | 1 | A register write is offered |
| wr_ready | input | 1 | The write port below accepts the write |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| vcom_start | output | 1 | One-cycle start pulse for the common-voltage sender |
| vcom_value | output | 8 | Common-voltage code to send |
| vcom_base | output | 8 | Supply-bit pattern the sender keeps during the transfer |
| vcom_done | input | 1 | The sender has finished |
| busy | output | 1 | A sequence is running |
| panel_on | output | 1 | The panel is initialised |

## Verification
A table of requests is walked in a fixed order so that the same power-on input hits the panel both cold and warm. The cold case exposes the full write order, the waits and the hand-off. The warm case shows that only phase and resolution are written. The entries differ in resolution and in trim validity, which separates the phase rule for quarter resolution, for a valid full-resolution trim and for an invalid one, and which separates the common-voltage default from a supplied trim. In every entry the trim and select inputs are scrambled right after the start, and a ready signal that stalls every fourth cycle exercises the port's hold behaviour. A directed test then queues power-off and power-on together during a running power-up, to show that requests are kept and which one is served first.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int IW = 5;
  localparam int LONGEST_MS = 34;

  typedef enum logic [1:0] {SEQ_COLD, SEQ_WARM, SEQ_DOWN} seq_e;
  typedef enum logic [1:0] {K_WR, K_MS, K_VC, K_END} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   data;
  } step_t;

  localparam logic [AW-1:0] A_RES = 3'd0;
  localparam logic [AW-1:0] A_PHS = 3'd1;
  localparam logic [AW-1:0] A_PW0 = 3'd3;
  localparam logic [AW-1:0] A_PW1 = 3'd4;
  localparam logic [AW-1:0] A_IFC = 3'd6;
  localparam logic [AW-1:0] A_POL = 3'd7;

  localparam logic [DW-1:0] VBASE_UP = 8'h04;
  localparam logic [DW-1:0] VBASE_DN = 8'h14;

  function automatic logic [DW-1:0] phase_code(logic qvga, logic [3:0] trim,
                                               logic vld, logic [3:0] qv_def);
    if (qvga)     return {3'b000, qv_def, 1'b1};
    else if (vld) return {3'b000, trim, 1'b1};
    else          return 8'h01;
  endfunction

  function automatic logic [DW-1:0] vcom_code(logic [DW-1:0] trim, logic vld,
                                              logic [DW-1:0] def);
    return vld ? trim : def;
  endfunction

  function automatic step_t mk(kind_e k, logic [AW-1:0] a, logic [DW-1:0] d);
    step_t s;
    s.kind = k;
    s.addr = a;
    s.data = d;
    return s;
  endfunction

  function automatic step_t step_at(seq_e seq, logic [IW-1:0] idx,
                                    logic [DW-1:0] ph, logic [DW-1:0] res,
                                    logic [DW-1:0] vc);
    step_t s;
    s = mk(K_END, '0, '0);
    case (seq)
      SEQ_COLD: case (int'(idx))
        0:  s = mk(K_WR, A_IFC, 8'h1F);
        1:  s = mk(K_WR, A_PW0, 8'h03);
        2:  s = mk(K_WR, A_PW1, 8'h00);
        3:  s = mk(K_WR, A_PW1, 8'h04);
        4:  s = mk(K_MS, '0,    8'd3);
        5:  s = mk(K_WR, A_PW0, 8'h07);
        6:  s = mk(K_WR, A_IFC, 8'h09);
        7:  s = mk(K_VC, '0,    vc);
        8:  s = mk(K_WR, A_PW0, 8'h17);
        9:  s = mk(K_WR, A_PW1, 8'h06);
        10: s = mk(K_MS, '0,    8'd2);
        11: s = mk(K_WR, A_IFC, 8'h01);
        12: s = mk(K_WR, A_PW0, 8'h1F);
        13: s = mk(K_WR, A_PW1, 8'h07);
        14: s = mk(K_WR, A_IFC, 8'h00);
        15: s = mk(K_WR, A_PHS, ph);
        16: s = mk(K_WR, A_POL, 8'h00);
        17: s = mk(K_MS, '0,    8'd1);
        18: s = mk(K_WR, A_RES, res);
        default: s = mk(K_END, '0, '0);
      endcase
      SEQ_WARM: case (int'(idx))
        0:  s = mk(K_WR, A_PHS, ph);
        1:  s = mk(K_WR, A_RES, res);
        default: s = mk(K_END, '0, '0);
      endcase
      SEQ_DOWN: case (int'(idx))
        0:  s = mk(K_MS, '0,    8'(LONGEST_MS));
        1:  s = mk(K_WR, A_PW1, 8'h06);
        2:  s = mk(K_WR, A_IFC, 8'h08);
        3:  s = mk(K_WR, A_PW0, 8'h14);
        4:  s = mk(K_VC, '0,    8'h00);
        5:  s = mk(K_WR, A_PW1, 8'h04);
        6:  s = mk(K_WR, A_PW0, 8'h04);
        7:  s = mk(K_WR, A_IFC, 8'h1E);
        8:  s = mk(K_WR, A_PW0, 8'h00);
        9:  s = mk(K_WR, A_PW1, 8'h00);
        default: s = mk(K_END, '0, '0);
      endcase
      default: s = mk(K_END, '0, '0);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lps_ms_timer.sv
module lps_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MAX_MS     = 34,
  parameter int MSW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [MSW-1:0] ms,
  output logic           run,
  output logic           expire
);
  localparam int CW = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] span(logic [MSW-1:0] m);
    return CW'(m) * CW'(CYC_PER_MS) - CW'(1);
  endfunction

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      run   <= 1'b1;
      cnt_q <= span(ms);
    end else if (run) begin
      if (cnt_q == '0) run <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/lps_wr_port.sv
module lps_wr_port #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          free
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= ld_addr;
      wr_data  <= ld_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lps_step_rom.sv
module lps_step_rom
  import lps_pkg::*;
(
  input  seq_e          seq,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] ph,
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] vc,
  output step_t         cur
);
  assign cur = step_at(seq, idx, ph, res, vc);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lps_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int DEF_VCOM   = 125,
  parameter int QVGA_PHASE = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on_req,
  input  logic          pwr_off_req,
  input  logic          res_qvga,
  input  logic [7:0]    vcom_trim,
  input  logic          vcom_trim_vld,
  input  logic [3:0]    phase_trim,
  input  logic          phase_trim_vld,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [2:0]    wr_addr,
  output logic [7:0]    wr_data,
  output logic          vcom_start,
  output logic [7:0]    vcom_value,
  output logic [7:0]    vcom_base,
  input  logic          vcom_done,
  output logic          busy,
  output logic          panel_on
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TWAIT, ST_VWAIT} st_e;

  st_e           st_q;
  seq_e          seq_q;
  logic [IW-1:0] idx_q;
  logic          qvga_q;
  logic [DW-1:0] ph_q, vc_q, res_w;
  logic          on_pend, off_pend;
  step_t         cur;

  // named events for the checker
  logic ld, tmr_go, vc_go, fin, start_up, start_dn;
  logic port_free, tmr_run, tmr_done, vc_wait;

  assign res_w    = {{(DW-1){1'b0}}, qvga_q};
  assign start_dn = (st_q == ST_IDLE) && off_pend;
  assign start_up = (st_q == ST_IDLE) && !off_pend && on_pend;
  assign vc_wait  = (st_q == ST_VWAIT);
  assign busy     = (st_q != ST_IDLE);

  lps_step_rom u_rom (
    .seq (seq_q),
    .idx (idx_q),
    .ph  (ph_q),
    .res (res_w),
    .vc  (vc_q),
    .cur (cur)
  );

  lps_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MAX_MS     (LONGEST_MS),
    .MSW        (DW)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (tmr_go),
    .ms     (cur.data),
    .run    (tmr_run),
    .expire (tmr_done)
  );

  lps_wr_port #(.AW(AW), .DW(DW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .ld_addr  (cur.addr),
    .ld_data  (cur.data),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .free     (port_free)
  );

  always_comb begin
    ld     = 1'b0;
    tmr_go = 1'b0;
    vc_go  = 1'b0;
    fin    = 1'b0;
    if (st_q == ST_RUN) begin
      case (cur.kind)
        K_WR:    ld     = port_free;
        K_MS:    tmr_go = !wr_valid;
        K_VC:    vc_go  = !wr_valid;
        default: fin    = !wr_valid;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      seq_q      <= SEQ_COLD;
      idx_q      <= '0;
      qvga_q     <= 1'b0;
      ph_q       <= '0;
      vc_q       <= '0;
      on_pend    <= 1'b0;
      off_pend   <= 1'b0;
      panel_on   <= 1'b0;
      vcom_start <= 1'b0;
      vcom_value <= '0;
      vcom_base  <= '0;
    end else begin
      on_pend    <= (on_pend  && !start_up) || pwr_on_req;
      off_pend   <= (off_pend && !start_dn) || pwr_off_req;
      vcom_start <= vc_go;
      if (vc_go) begin
        vcom_value <= cur.data;
        vcom_base  <= (seq_q == SEQ_DOWN) ? VBASE_DN : VBASE_UP;
      end
      case (st_q)
        ST_IDLE: if (start_dn || start_up) begin
          seq_q  <= start_dn ? SEQ_DOWN : (panel_on ? SEQ_WARM : SEQ_COLD);
          idx_q  <= '0;
          qvga_q <= res_qvga;
          ph_q   <= phase_code(res_qvga, phase_trim, phase_trim_vld, 4'(QVGA_PHASE));
          vc_q   <= vcom_code(vcom_trim, vcom_trim_vld, 8'(DEF_VCOM));
          st_q   <= ST_RUN;
        end
        ST_RUN: begin
          if (ld)          idx_q <= idx_q + IW'(1);
          else if (tmr_go) st_q  <= ST_TWAIT;
          else if (vc_go)  st_q  <= ST_VWAIT;
          else if (fin) begin
            panel_on <= (seq_q != SEQ_DOWN);
            st_q     <= ST_IDLE;
          end
        end
        ST_TWAIT: if (tmr_done) begin
          idx_q <= idx_q + IW'(1);
          st_q  <= ST_RUN;
        end
        default: if (vcom_done) begin
          idx_q <= idx_q + IW'(1);
          st_q  <= ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/lps_chk.sv
module lps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       vcom_start,
  input logic       panel_on,
  input logic       tmr_run,
  input logic       vc_wait
);
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !tmr_run && !vc_wait);

  // R3
  wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> !wr_valid);

  // R4
  handoff_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vc_wait |-> !wr_valid);

  // R4
  vcom_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcom_start |=> !vcom_start);

  // R4
  vcom_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcom_start |-> busy && vc_wait);

  // R2 R8
  pon_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_on != $past(panel_on)) |-> $fell(busy));
endmodule

bind lcd_pwr_seq lps_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .vcom_start (vcom_start),
  .panel_on   (panel_on),
  .tmr_run    (tmr_run),
  .vc_wait    (vc_wait)
);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;
  localparam int CLK_HZ_TB = 10_000;
  localparam int CPM = CLK_HZ_TB / 1000;
  localparam int NV = 9;
  // {off, qvga, vcom trim, vcom vld, phase trim, phase vld}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h55, 1'b1, 4'h5, 1'b1},
    {1'b0, 1'b1, 8'h22, 1'b1, 4'h3, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0},
    {1'b0, 1'b1, 8'h9A, 1'b0, 4'h7, 1'b1},
    {1'b0, 1'b0, 8'h11, 1'b1, 4'hF, 1'b1},
    {1'b1, 1'b1, 8'h33, 1'b1, 4'h2, 1'b1},
    {1'b0, 1'b0, 8'hC8, 1'b1, 4'h6, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic       res_qvga = 1'b0;
  logic [7:0] vcom_trim = '0;
  logic       vcom_trim_vld = 1'b0;
  logic [3:0] phase_trim = '0;
  logic       phase_trim_vld = 1'b0;
  logic       wr_valid, wr_ready = 1'b1;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       vcom_start, vcom_done = 1'b0;
  logic [7:0] vcom_value, vcom_base;
  logic       busy, panel_on;

  int checks = 0, errors = 0, cyc = 0;

  lcd_pwr_seq #(.CLK_HZ(CLK_HZ_TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .res_qvga(res_qvga), .vcom_trim(vcom_trim), .vcom_trim_vld(vcom_trim_vld),
    .phase_trim(phase_trim), .phase_trim_vld(phase_trim_vld),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .vcom_start(vcom_start), .vcom_value(vcom_value), .vcom_base(vcom_base),
    .vcom_done(vcom_done), .busy(busy), .panel_on(panel_on)
  );

  // observed traffic
  logic [2:0] got_a [256];
  logic [7:0] got_d [256];
  int         got_c [256];
  int         n_got = 0;
  logic [7:0] gv_d [16];
  logic [7:0] gv_b [16];
  int         gv_w [16];
  int         n_gv = 0;
  int         i2c_cnt = 0, hold_err = 0, stalls = 0;
  logic       stall_q = 1'b0;
  logic [2:0] st_a = '0;
  logic [7:0] st_d = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    wr_ready = (cyc % 4) != 3;
    if (stall_q && (!wr_valid || wr_addr != st_a || wr_data != st_d)) hold_err++;
    stall_q = rst_n && wr_valid && !wr_ready;
    if (stall_q) stalls++;
    st_a = wr_addr;
    st_d = wr_data;
    if (rst_n && wr_valid && wr_ready && n_got < 256) begin
      got_a[n_got] = wr_addr;
      got_d[n_got] = wr_data;
      got_c[n_got] = cyc;
      n_got++;
    end
    vcom_done = 1'b0;
    if (i2c_cnt > 0) begin
      i2c_cnt--;
      if (i2c_cnt == 0) vcom_done = 1'b1;
    end else if (rst_n && vcom_start && n_gv < 16) begin
      gv_d[n_gv] = vcom_value;
      gv_b[n_gv] = vcom_base;
      gv_w[n_gv] = n_got;
      n_gv++;
      i2c_cnt = 7;
    end
  end

  // expected traffic
  logic [2:0] ex_a [128];
  logic [7:0] ex_d [128];
  int         n_ex = 0;
  logic       model_on = 1'b0;
  int         req_cyc = 0;

  task automatic push(input logic [2:0] a, input logic [7:0] d);
    ex_a[n_ex] = a; ex_d[n_ex] = d; n_ex++;
  endtask

  task automatic build_cold(input logic [7:0] ph, input logic [7:0] rs);
    push(6, 8'h1F); push(3, 8'h03); push(4, 8'h00); push(4, 8'h04);
    push(3, 8'h07); push(6, 8'h09); push(3, 8'h17); push(4, 8'h06);
    push(6, 8'h01); push(3, 8'h1F); push(4, 8'h07); push(6, 8'h00);
    push(1, ph);    push(7, 8'h00); push(0, rs);
  endtask

  task automatic build_warm(input logic [7:0] ph, input logic [7:0] rs);
    push(1, ph); push(0, rs);
  endtask

  task automatic build_down();
    push(4, 8'h06); push(6, 8'h08); push(3, 8'h14); push(4, 8'h04);
    push(3, 8'h04); push(6, 8'h1E); push(3, 8'h00); push(4, 8'h00);
  endtask

  function automatic logic [7:0] exp_phase(logic q, logic [3:0] t, logic v);
    if (q) return 8'd19;
    if (v) return 8'(t) * 8'd2 + 8'd1;
    return 8'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_writes(input int base, input string tag);
    int n, bad;
    n = n_got - base;
    bad = -1;
    if (n == n_ex) begin
      for (int k = 0; k < n_ex; k++)
        if (bad < 0 && (got_a[base+k] != ex_a[k] || got_d[base+k] != ex_d[k])) bad = k;
      if (bad >= 0)
        chk(0, tag, $sformatf("write %0d addr/data", bad),
            {24'd0, 5'd0, got_a[base+bad]} * 256 + int'(got_d[base+bad]),
            {24'd0, 5'd0, ex_a[bad]} * 256 + int'(ex_d[bad]));
      else chk(1, tag, "writes", n, n_ex);
    end else chk(0, tag, "write count", n, n_ex);
  endtask

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    pwr_on_req = on; pwr_off_req = off; req_cyc = cyc;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
  endtask

  task automatic run_until_quiet();
    int q = 0, guard = 0;
    while (q < 5 && guard < 5000) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
      guard++;
    end
    chk(guard < 5000, "R11", "busy never dropped", guard, 5000);
  endtask

  task automatic gap(input int c0, input int c1, input int ms, input string tag);
    int g;
    g = c1 - c0;
    chk(g >= ms * CPM && g <= ms * CPM + 20, tag, $sformatf("%0d ms wait spacing", ms),
        g, ms * CPM);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic op, q, cv, pv, cold;
    logic [7:0] ct, ph, rs;
    logic [3:0] pt;
    int wb, vb;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !vcom_start && !panel_on, "R1", "outputs in reset",
        {28'd0, busy, wr_valid, vcom_start, panel_on}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_valid && !vcom_start && !panel_on, "R1", "outputs after reset",
        {28'd0, busy, wr_valid, vcom_start, panel_on}, 0);

    for (int v = 0; v < NV; v++) begin
      {op, q, ct, cv, pt, pv} = VEC[v];
      res_qvga = q; vcom_trim = ct; vcom_trim_vld = cv;
      phase_trim = pt; phase_trim_vld = pv;
      ph = exp_phase(q, pt, pv);
      rs = q ? 8'd1 : 8'd0;
      cold = !op && !model_on;
      n_ex = 0; wb = n_got; vb = n_gv;
      if (op) build_down();
      else if (model_on) build_warm(ph, rs);
      else build_cold(ph, rs);
      pulse(!op, op);
      @(negedge clk);
      chk(busy, "R11", "busy after request", int'(busy), 1);
      // R12: scramble the sampled inputs once the sequence is under way
      res_qvga = ~q; vcom_trim = ~ct; vcom_trim_vld = ~cv;
      phase_trim = ~pt; phase_trim_vld = ~pv;
      run_until_quiet();
      if (op) begin
        cmp_writes(wb, "R8 R12");
        chk(n_gv - vb == 1 && gv_d[vb] == 8'h00 && gv_b[vb] == 8'h14 && gv_w[vb] - wb == 3,
            "R8 R4", "down hand-off value/base/position",
            int'(gv_d[vb]) * 256 + int'(gv_b[vb]), 8'h14);
        if (n_got - wb > 0) gap(req_cyc, got_c[wb], 34, "R3 R8");
      end else if (cold) begin
        cmp_writes(wb, "R2 R5 R6 R12");
        chk(n_gv - vb == 1 && gv_d[vb] == (cv ? ct : 8'd125) && gv_b[vb] == 8'h04
            && gv_w[vb] - wb == 6, "R4", "up hand-off value/base/position",
            int'(gv_d[vb]), cv ? int'(ct) : 125);
        if (n_got - wb == 15) begin
          gap(got_c[wb+3], got_c[wb+4], 3, "R3");
          gap(got_c[wb+7], got_c[wb+8], 2, "R3");
          gap(got_c[wb+13], got_c[wb+14], 1, "R3");
        end
      end else begin
        cmp_writes(wb, "R7 R5 R6 R12");
        chk(n_gv == vb, "R7", "hand-off count in warm power-on", n_gv - vb, 0);
      end
      model_on = !op;
      chk(panel_on == model_on, op ? "R8" : "R2 R7", "panel_on", int'(panel_on), int'(model_on));
    end

    // R9: both requests queued during a cold power-up
    res_qvga = 1'b0; vcom_trim = 8'h40; vcom_trim_vld = 1'b1;
    phase_trim = 4'h2; phase_trim_vld = 1'b1;
    n_ex = 0; wb = n_got; vb = n_gv;
    build_cold(8'h05, 8'h00);
    build_down();
    build_cold(8'h05, 8'h00);
    pulse(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    pulse(1'b1, 1'b1);
    run_until_quiet();
    cmp_writes(wb, "R9");
    chk(n_gv - vb == 3, "R9", "hand-off count", n_gv - vb, 3);
    chk(panel_on, "R9", "panel_on after queued on", int'(panel_on), 1);

    // R10: port holds during stalls
    chk(hold_err == 0 && stalls > 0, "R10", "hold violations", hold_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule